// File: doc/BRIEF.md
# Sub-Block Running Disparity Checker

This block watches the received code words of one serial lane and tracks the running disparity (the running ones-minus-zeros sum) across every sub-block boundary. Each 10-bit word is made of a 6-bit leading sub-block and a 4-bit trailing sub-block. Both sub-blocks obey the same balance rules, so either one can compensate the other. The block raises a flag for any sub-block whose own imbalance is not allowed, or whose imbalance would drive the running disparity out of its permitted set.

A word is examined only when `in_valid` is high. The leading sub-block is scored first against the disparity stored from the last word. The trailing sub-block is then scored against whatever the leading one left behind. The running disparity, one error flag per sub-block and an output-valid strobe appear one clock later. The disparity may rest at ±1 or ±3 at a boundary, and sub-block imbalances of ±4 are accepted.

Top module: `subblock_rd_checker`

## Requirements
- R1: The leading sub-block is `code_word[5:0]` and the trailing sub-block is `code_word[9:6]`. Each bit adds +1 to the sum when it is one and -1 when it is zero. The leading sub-block is applied before the trailing one.
- R2: A leading sub-block whose imbalance is ±6 (all ones or all zeros) is illegal. It sets `err_lead` and leaves the disparity as it was.
- R3: After reset, `rd_out` is -1, `out_valid` is 0, and `err_lead` and `err_tail` are 0.
- R4: A sub-block with equal numbers of ones and zeros leaves the running disparity unchanged.
- R5: A sub-block whose imbalance would move the disparity outside {-3, -1, +1, +3} sets its own error flag (`err_lead` or `err_tail`) and leaves the disparity unchanged.
- R6: The trailing sub-block is judged against the disparity left by the leading sub-block. If the leading sub-block was in error, that is the unchanged earlier value.
- R7: An imbalance of ±4 is accepted without error whenever the resulting disparity stays within ±3.
- R8: `out_valid` is `in_valid` delayed by one clock. The `rd_out` and error flags for a word appear in that same cycle.
- R9: While `in_valid` is low, the error flags read 0 one cycle later and `rd_out` holds its value, whatever `code_word` carries.
- R10: `rd_out` is a 5-bit two's-complement value. It is always one of -3, -1, +1 or +3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when `code_word` carries a word to check |
| code_word | input | 10 | Received word: [5:0] leading sub-block, [9:6] trailing sub-block |
| out_valid | output | 1 | Registered copy of `in_valid` |
| rd_out | output | 5 | Running disparity, two's complement |
| err_lead | output | 1 | Leading sub-block broke a rule (1 = error) |
| err_tail | output | 1 | Trailing sub-block broke a rule (1 = error) |

## Verification
The properties take `in_valid` and `code_word` to be known, settled values at every rising edge once reset is released. They also assume that reset is held long enough for the disparity register to load its start value. The stimulus changes inputs only on falling edges and never leaves `code_word` undefined while `in_valid` is high. The word sequence is arranged so that every disparity level is reached. Along the way it exercises legal ±4 moves, overflows past ±3 in both directions, both illegal leading patterns, and words where both sub-blocks fail together.

// File: rtl/sbrd_pkg.sv
package sbrd_pkg;
   // signed width wide enough for a disparity plus one sub-block imbalance
   localparam int RD_W = 5;
   typedef logic signed [RD_W-1:0] rd_t;
endpackage

// File: rtl/sbrd_imbalance.sv
module sbrd_imbalance
   import sbrd_pkg::*;
#(
   parameter int W     = 6,
   parameter int LIMIT = 4
) (
   input  logic [W-1:0] bits,
   output rd_t          imb,
   output logic         legal
);
   rd_t ones;

   always_comb begin
      ones = '0;
      for (int i = 0; i < W; i++) begin
         ones = ones + rd_t'({1'b0, bits[i]});
      end
   end

   // ones - zeros = 2*ones - W
   assign imb   = (ones <<< 1) - rd_t'(W);
   assign legal = (imb <= rd_t'(LIMIT)) && (imb >= -rd_t'(LIMIT));
endmodule

// File: rtl/sbrd_step.sv
module sbrd_step
   import sbrd_pkg::*;
#(
   parameter int LIMIT = 3
) (
   input  rd_t  rd_in,
   input  rd_t  imb,
   input  logic legal,
   output rd_t  rd_next,
   output logic err
);
   rd_t  sum;
   logic in_range;

   assign sum      = rd_in + imb;
   assign in_range = (sum <= rd_t'(LIMIT)) && (sum >= -rd_t'(LIMIT));
   assign err      = !legal || !in_range;
   assign rd_next  = err ? rd_in : sum;
endmodule

// File: rtl/subblock_rd_checker.sv
module subblock_rd_checker
   import sbrd_pkg::*;
#(
   parameter  int LEAD_W    = 6,
   parameter  int TAIL_W    = 4,
   parameter  int RD_LIMIT  = 3,
   parameter  int IMB_LIMIT = 4,
   parameter  int RD_INIT   = -1,
   localparam int WORD_W    = LEAD_W + TAIL_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [WORD_W-1:0]      code_word,
   output logic                   out_valid,
   output logic signed [RD_W-1:0] rd_out,
   output logic                   err_lead,
   output logic                   err_tail
);
   localparam int NSUB = 2;
   localparam int SUB_W   [NSUB] = '{LEAD_W, TAIL_W};
   localparam int SUB_OFF [NSUB] = '{0, LEAD_W};
   localparam int MAX_W   = (LEAD_W > TAIL_W) ? LEAD_W : TAIL_W;

   // elaboration-time parameter checks
   if ((LEAD_W % 2) != 0 || (TAIL_W % 2) != 0) begin : g_bad_width
      $error("sub-block widths must be even");
   end
   if ((RD_INIT % 2) == 0 || RD_INIT > RD_LIMIT || RD_INIT < -RD_LIMIT) begin : g_bad_init
      $error("RD_INIT must be odd and within the disparity limit");
   end
   if (RD_LIMIT + MAX_W > (1 << (RD_W - 1)) - 1) begin : g_bad_range
      $error("disparity arithmetic width too small for these widths");
   end
   if ((IMB_LIMIT % 2) != 0 || IMB_LIMIT > MAX_W) begin : g_bad_imb
      $error("IMB_LIMIT must be even and no larger than a sub-block");
   end

   rd_t              rd_q;
   rd_t              rd_chain [NSUB+1];
   logic [NSUB-1:0]  err_vec;
   logic [NSUB-1:0]  err_q;
   logic             vld_q;

   assign rd_chain[0] = rd_q;

   for (genvar g = 0; g < NSUB; g++) begin : g_sub
      localparam int W   = SUB_W[g];
      localparam int OFF = SUB_OFF[g];
      rd_t  imb;
      logic legal;

      sbrd_imbalance #(.W(W), .LIMIT(IMB_LIMIT)) u_imb (
         .bits  (code_word[OFF +: W]),
         .imb   (imb),
         .legal (legal)
      );

      sbrd_step #(.LIMIT(RD_LIMIT)) u_step (
         .rd_in   (rd_chain[g]),
         .imb     (imb),
         .legal   (legal),
         .rd_next (rd_chain[g+1]),
         .err     (err_vec[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= rd_t'(RD_INIT);
         err_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            rd_q  <= rd_chain[NSUB];
            err_q <= err_vec;
         end else begin
            err_q <= '0;
         end
      end
   end

   assign out_valid = vld_q;
   assign rd_out    = rd_q;
   assign err_lead  = err_q[0];
   assign err_tail  = err_q[1];
endmodule

// File: rtl/sbrd_checker.sv
module sbrd_checker
   import sbrd_pkg::*;
#(
   parameter int LEAD_W = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic [LEAD_W-1:0]      lead_bits,
   input logic                   out_valid,
   input logic signed [RD_W-1:0] rd_out,
   input logic                   err_lead,
   input logic                   err_tail
);
   // R10
   rd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_out == 5'sd3) || (rd_out == 5'sd1) || (rd_out == -5'sd1) || (rd_out == -5'sd3));

   // R8
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R8
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(rd_out));

   // R9
   idle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!err_lead && !err_tail));

   // R2
   lead_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ((&lead_bits) || !(|lead_bits))) |=> err_lead);

   // R5
   both_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && err_lead && err_tail) |-> (rd_out == $past(rd_out)));
endmodule

bind subblock_rd_checker sbrd_checker #(.LEAD_W(LEAD_W)) u_sbrd_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .lead_bits (code_word[LEAD_W-1:0]),
   .out_valid (out_valid),
   .rd_out    (rd_out),
   .err_lead  (err_lead),
   .err_tail  (err_tail)
);

// File: tb/tb_subblock_rd_checker.sv
`timescale 1ns/1ps
module tb_subblock_rd_checker;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [9:0]        code_word = '0;
   logic              out_valid;
   logic signed [4:0] rd_out;
   logic              err_lead;
   logic              err_tail;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   subblock_rd_checker dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .code_word (code_word),
      .out_valid (out_valid),
      .rd_out    (rd_out),
      .err_lead  (err_lead),
      .err_tail  (err_tail)
   );

   // {code_word, expected rd, expected err_lead, expected err_tail}
   localparam int NV = 12;
   localparam logic [16:0] VEC [NV] = '{
      {10'h0C7, 5'b11111, 1'b0, 1'b0},  // R4: both balanced, stays -1
      {10'h3DF, 5'b00011, 1'b0, 1'b1},  // R7: lead +4 to +3; R5: tail +4 overflows
      {10'h001, 5'b11111, 1'b0, 1'b1},  // R7: lead -4 to -1; R5: tail -4 underflows
      {10'h1FF, 5'b00001, 1'b1, 1'b0},  // R2: lead all ones; R6: tail +2 from -1
      {10'h040, 5'b11111, 1'b1, 1'b0},  // R2: lead all zeros; R6: tail -2 from +1
      {10'h003, 5'b11101, 1'b0, 1'b1},  // R1: lead -2 to -3; tail -4 underflows
      {10'h3CF, 5'b00011, 1'b0, 1'b0},  // R1: lead +2 then tail +4 to +3
      {10'h215, 5'b00001, 1'b0, 1'b0},  // R4: lead balanced; tail -2
      {10'h137, 5'b11111, 1'b1, 1'b0},  // R5: lead +4 from +1 overflows; R6 tail -2
      {10'h3C0, 5'b00011, 1'b1, 1'b0},  // R6: tail +4 from kept -1
      {10'h3BF, 5'b00011, 1'b1, 1'b1},  // R5: both fail, rd kept
      {10'h020, 5'b11111, 1'b0, 1'b1}   // R7: lead -4 to -1; tail underflows
   };

   task automatic check(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R3: reset state
      check("R3", "out_valid", int'(out_valid), 0);
      check("R3", "rd_out", int'(rd_out), -1);
      check("R3", "err_lead", int'(err_lead), 0);
      check("R3", "err_tail", int'(err_tail), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table, words back to back
      for (int i = 0; i < NV; i++) begin
         in_valid  = 1'b1;
         code_word = VEC[i][16:7];
         @(negedge clk);
         check("R8", "out_valid", int'(out_valid), 1);
         check("R1", "rd_out", int'(rd_out), int'($signed(VEC[i][6:2])));
         check("R5", "err_lead", int'(err_lead), int'(VEC[i][1]));
         check("R6", "err_tail", int'(err_tail), int'(VEC[i][0]));
         // R10: disparity set
         check("R10", "rd_out legal", int'(rd_out == 5'sd3 || rd_out == 5'sd1 ||
               rd_out == -5'sd1 || rd_out == -5'sd3), 1);
      end

      // R9: idle with an illegal pattern on the input, rd stays -1
      in_valid  = 1'b0;
      code_word = 10'h3FF;
      repeat (3) begin
         @(negedge clk);
         check("R9", "out_valid", int'(out_valid), 0);
         check("R9", "err_lead", int'(err_lead), 0);
         check("R9", "err_tail", int'(err_tail), 0);
         check("R9", "rd_out", int'(rd_out), -1);
      end

      // R7: lead +4 from -1 to +3, balanced tail
      in_valid  = 1'b1;
      code_word = 10'h0DF;
      @(negedge clk);
      in_valid = 1'b0;
      check("R7", "rd_out", int'(rd_out), 3);
      check("R7", "err_lead", int'(err_lead), 0);

      // R3: reset mid-stream restores -1
      rst_n = 1'b0;
      @(negedge clk);
      check("R3", "rd_out after reset", int'(rd_out), -1);
      check("R3", "out_valid after reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule